// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This controller brings a contact smart card up and takes it down in a fixed order. A falling edge on the active-low activate command starts power-up. The card-presence contact must already be debounced as present, and no fault flag may be raised. The sequencer then asserts, one after another, an oscillator start, an oscillator fast-mode select, the card supply ramp enable, the host-side I/O line enable and the card clock enable. Its last step hands the card reset over to the host. Consecutive steps are spaced by a step interval that is programmable in reference clock cycles.

Power-down reverses the order and keeps the same spacing. Raising the command starts it in an orderly way. It also starts by itself if an overcurrent, overtemperature or supply alarm flag rises, or if the debounced presence input reports that the card has been withdrawn. The raw presence contact passes through a two-stage synchronizer and a restartable stability counter before it is believed. A single active-low status pin reports two things: whether the card is present, and whether the last power-down was forced rather than requested.

Top module: `cardPowerSeq`

## Requirements
- R1: After reset, all six sequence outputs are low. The status output `alertN` is also low, because the card is taken as absent until debounce accepts it.
- R2: Activation needs a high-to-low transition of `actCmdN`. A command that is already low when the card becomes present starts nothing. `oscEn` rises on the first clock edge that sees the transition.
- R3: Power-up asserts `oscEn`, `oscFast`, `vccEn`, `ioEn`, `clkEn` and then the internal reset hand-over, in that order. Each is exactly `stepGap` cycles after the one before, and a `stepGap` of 0 acts as 1.
- R4: `cardRst` equals `hostRst` delayed by one cycle, without inversion, but only once the reset hand-over step is done. At all other times it stays low.
- R5: Power-down starts on the first clock edge after any of these: `faultOvercur`, `faultOvertemp` or `supplyAlarm` goes high, debounced presence drops, or `actCmdN` returns high. This holds from any power-up step or from the fully active state.
- R6: Power-down clears `cardRst` at its first edge. It then clears `clkEn`, then `ioEn`, then `vccEn`, and finally `oscEn` and `oscFast` together, one `stepGap` apart.
- R7: A falling command edge has no effect in four cases: during power-down, while the card is not debounced present, while any fault flag is high, or when no fresh high-to-low transition has occurred.
- R8: A presence change is accepted only after the synchronized raw input has differed from the accepted value for `DEB_CYCLES` consecutive cycles. Any return to the accepted value restarts the count. Raw low means the card is present.
- R9: `alertN` is high only while the card is debounced present and no forced power-down (fault or removal) has occurred since the last accepted activation. A power-down requested through the command leaves it high.
- R10: A power-down that begins part-way through power-up never asserts any step that was not yet reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepGap | input | STEP_W | Cycles between sequence steps (0 acts as 1) |
| actCmdN | input | 1 | Active-low activate command |
| presRawN | input | 1 | Raw card-presence contact, low when card inserted |
| faultOvercur | input | 1 | Supply short or overload flag |
| faultOvertemp | input | 1 | Overtemperature flag |
| supplyAlarm | input | 1 | Low supply alarm flag |
| hostRst | input | 1 | Host reset request for the card |
| oscEn | output | 1 | Internal oscillator start |
| oscFast | output | 1 | Oscillator high-frequency select |
| vccEn | output | 1 | Card supply ramp enable |
| ioEn | output | 1 | Host-side I/O line enable |
| clkEn | output | 1 | Card clock enable |
| cardRst | output | 1 | Card reset line |
| alertN | output | 1 | Low when card absent or after a forced power-down |

## Verification
The bench aims at a bouncing presence contact. Its bounce would be accepted early by a filter that only accumulates and never restarts. It drops an overtemperature flag midway through power-up, after the supply step but before the I/O step. A sequencer that let the pending step fire, or that jumped straight to the last clear, would produce an extra or missing output edge there, and the edge-by-edge scoreboard would catch it. It re-issues the command during power-down, under a held fault, and with the command already low when the card returns. These are the points where a level-sensitive or unguarded start would power the card back up. A step interval of zero is also run, where an unclamped counter would stall or wrap.

// File: rtl/cardSeqPkg.sv
package cardSeqPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_FAST,
    ST_UP_VCC,
    ST_UP_IO,
    ST_UP_CLK,
    ST_UP_RST,
    ST_ON,
    ST_DN_CLK,
    ST_DN_IO,
    ST_DN_VCC,
    ST_DN_OSC
  } seqState_e;

  typedef struct packed {
    logic setOsc;
    logic setFast;
    logic setVcc;
    logic setIo;
    logic setClk;
    logic setRst;
    logic clrRst;
    logic clrClk;
    logic clrIo;
    logic clrVcc;
    logic clrOsc;
    logic setAlert;
    logic clrAlert;
  } seqStrobe_t;

endpackage

// File: rtl/presenceFilter.sv
module presenceFilter #(
  parameter int DEB_CYCLES = 1600000
) (
  input  logic clk,
  input  logic rstN,
  input  logic presRawN,
  output logic presentDeb
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic metaN, syncN, stableN;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaN   <= 1'b1;
      syncN   <= 1'b1;
      stableN <= 1'b1;
      cnt     <= '0;
    end else begin
      metaN <= presRawN;
      syncN <= metaN;
      if (syncN != stableN) begin
        if (cnt == CNT_LAST) begin
          stableN <= syncN;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign presentDeb = ~stableN;

  // accepted value only moves when the stability window has been filled (R8)
  assert_settle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stableN) |-> $past(cnt) == CNT_LAST);

  // counter only runs while the synchronized input disagrees (R8)
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(syncN) == $past(stableN)) |-> cnt == '0);

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import cardSeqPkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [STEP_W-1:0] stepGap,
  input  logic              hostRst,
  output logic              tick,
  output logic              oscEn,
  output logic              oscFast,
  output logic              vccEn,
  output logic              ioEn,
  output logic              clkEn,
  output logic              cardRst,
  output logic              alertLatch
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  logic [STEP_W-1:0] timer;
  logic [STEP_W-1:0] gapEff;
  logic              rstCtl;
  logic              anyStep;

  assign gapEff  = (stepGap == '0) ? ONE : stepGap;
  assign anyStep = |strobe;
  assign tick    = (timer == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer      <= '0;
      oscEn      <= 1'b0;
      oscFast    <= 1'b0;
      vccEn      <= 1'b0;
      ioEn       <= 1'b0;
      clkEn      <= 1'b0;
      rstCtl     <= 1'b0;
      cardRst    <= 1'b0;
      alertLatch <= 1'b0;
    end else begin
      if (anyStep)            timer <= gapEff;
      else if (timer != '0)   timer <= timer - 1'b1;

      if (strobe.setOsc)      oscEn <= 1'b1;
      else if (strobe.clrOsc) oscEn <= 1'b0;

      if (strobe.setFast)     oscFast <= 1'b1;
      else if (strobe.clrOsc) oscFast <= 1'b0;

      if (strobe.setVcc)      vccEn <= 1'b1;
      else if (strobe.clrVcc) vccEn <= 1'b0;

      if (strobe.setIo)       ioEn <= 1'b1;
      else if (strobe.clrIo)  ioEn <= 1'b0;

      if (strobe.setClk)      clkEn <= 1'b1;
      else if (strobe.clrClk) clkEn <= 1'b0;

      if (strobe.clrRst) begin
        rstCtl  <= 1'b0;
        cardRst <= 1'b0;
      end else begin
        if (strobe.setRst) rstCtl <= 1'b1;
        cardRst <= rstCtl & hostRst;
      end

      if (strobe.setAlert)      alertLatch <= 1'b1;
      else if (strobe.clrAlert) alertLatch <= 1'b0;
    end
  end

  // every enabled stage implies all earlier stages are still on (R3, R6)
  assert_chain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rstCtl |-> clkEn) and (clkEn |-> ioEn) and (ioEn |-> vccEn)
    and (vccEn |-> oscFast) and (oscFast |-> oscEn));

  // card reset is a delayed, non-inverted copy of the host request (R4)
  assert_rst_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> ($past(hostRst) && $past(rstCtl)));

  // fast mode only turns on after the oscillator was already running (R3)
  assert_fast_after_osc_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscFast) |-> $past(oscEn));

endmodule

// File: rtl/seqControl.sv
module seqControl
  import cardSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actCmdN,
  input  logic       presentDeb,
  input  logic       anyFault,
  input  logic       tick,
  output seqStrobe_t strobe
);
  seqState_e state, stateNext;
  logic      actPrev;
  logic      cmdFall;
  logic      upPhase, dnPhase;
  logic      dropReq;

  assign cmdFall = actPrev & ~actCmdN;
  assign upPhase = state inside {ST_UP_FAST, ST_UP_VCC, ST_UP_IO, ST_UP_CLK, ST_UP_RST, ST_ON};
  assign dnPhase = state inside {ST_DN_CLK, ST_DN_IO, ST_DN_VCC, ST_DN_OSC};
  assign dropReq = anyFault | ~presentDeb | actCmdN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      actPrev <= 1'b1;
    end else begin
      state   <= stateNext;
      actPrev <= actCmdN;
    end
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (state == ST_IDLE) begin
      if (cmdFall && presentDeb && !anyFault) begin
        strobe.setOsc   = 1'b1;
        strobe.clrAlert = 1'b1;
        stateNext       = ST_UP_FAST;
      end
    end else if (upPhase) begin
      if (dropReq) begin
        strobe.clrRst   = 1'b1;
        strobe.setAlert = anyFault | ~presentDeb;
        stateNext       = ST_DN_CLK;
      end else if (tick) begin
        case (state)
          ST_UP_FAST: begin strobe.setFast = 1'b1; stateNext = ST_UP_VCC; end
          ST_UP_VCC:  begin strobe.setVcc  = 1'b1; stateNext = ST_UP_IO;  end
          ST_UP_IO:   begin strobe.setIo   = 1'b1; stateNext = ST_UP_CLK; end
          ST_UP_CLK:  begin strobe.setClk  = 1'b1; stateNext = ST_UP_RST; end
          ST_UP_RST:  begin strobe.setRst  = 1'b1; stateNext = ST_ON;     end
          default:    ;
        endcase
      end
    end else if (tick) begin
      case (state)
        ST_DN_CLK: begin strobe.clrClk = 1'b1; stateNext = ST_DN_IO;  end
        ST_DN_IO:  begin strobe.clrIo  = 1'b1; stateNext = ST_DN_VCC; end
        ST_DN_VCC: begin strobe.clrVcc = 1'b1; stateNext = ST_DN_OSC; end
        ST_DN_OSC: begin strobe.clrOsc = 1'b1; stateNext = ST_IDLE;   end
        default:   ;
      endcase
    end
  end

  // a fault seen while powering or powered sends the sequencer down next cycle (R5)
  assert_fault_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (upPhase && anyFault) |=> dnPhase);

  // power-down never re-enters power-up without passing through idle (R7)
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    dnPhase |=> (dnPhase || state == ST_IDLE));

  // at most one output step per cycle (R6)
  assert_one_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setOsc, strobe.setFast, strobe.setVcc, strobe.setIo,
              strobe.setClk, strobe.setRst, strobe.clrRst, strobe.clrClk,
              strobe.clrIo, strobe.clrVcc, strobe.clrOsc}));

endmodule

// File: rtl/cardPowerSeq.sv
module cardPowerSeq
  import cardSeqPkg::*;
#(
  parameter int STEP_W     = 8,
  parameter int DEB_CYCLES = 1600000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [STEP_W-1:0] stepGap,
  input  logic              actCmdN,
  input  logic              presRawN,
  input  logic              faultOvercur,
  input  logic              faultOvertemp,
  input  logic              supplyAlarm,
  input  logic              hostRst,
  output logic              oscEn,
  output logic              oscFast,
  output logic              vccEn,
  output logic              ioEn,
  output logic              clkEn,
  output logic              cardRst,
  output logic              alertN
);
  seqStrobe_t strobe;
  logic       presentDeb;
  logic       anyFault;
  logic       tick;
  logic       alertLatch;

  assign anyFault = faultOvercur | faultOvertemp | supplyAlarm;

  presenceFilter #(.DEB_CYCLES(DEB_CYCLES)) uFilter (
    .clk        (clk),
    .rstN       (rstN),
    .presRawN   (presRawN),
    .presentDeb (presentDeb)
  );

  seqControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .actCmdN    (actCmdN),
    .presentDeb (presentDeb),
    .anyFault   (anyFault),
    .tick       (tick),
    .strobe     (strobe)
  );

  seqDatapath #(.STEP_W(STEP_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stepGap    (stepGap),
    .hostRst    (hostRst),
    .tick       (tick),
    .oscEn      (oscEn),
    .oscFast    (oscFast),
    .vccEn      (vccEn),
    .ioEn       (ioEn),
    .clkEn      (clkEn),
    .cardRst    (cardRst),
    .alertLatch (alertLatch)
  );

  assign alertN = presentDeb & ~alertLatch;

  // status high implies the card has been accepted as present (R9)
  assert_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    alertN |-> presentDeb);

endmodule

// File: tb/sim_cardPowerSeq.sv
`timescale 1ns/1ps
module sim_cardPowerSeq;
  localparam int STEP_W = 8;
  localparam int DEB    = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN = 1'b0;
  logic [STEP_W-1:0] stepGap = 8'd5;
  logic actCmdN = 1'b1, presRawN = 1'b1;
  logic faultOvercur = 1'b0, faultOvertemp = 1'b0, supplyAlarm = 1'b0;
  logic hostRst = 1'b0;
  logic oscEn, oscFast, vccEn, ioEn, clkEn, cardRst, alertN;

  cardPowerSeq #(.STEP_W(STEP_W), .DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rstN(rstN), .stepGap(stepGap), .actCmdN(actCmdN),
    .presRawN(presRawN), .faultOvercur(faultOvercur), .faultOvertemp(faultOvertemp),
    .supplyAlarm(supplyAlarm), .hostRst(hostRst), .oscEn(oscEn), .oscFast(oscFast),
    .vccEn(vccEn), .ioEn(ioEn), .clkEn(clkEn), .cardRst(cardRst), .alertN(alertN));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] expVec[$];
  int         expCyc[$];
  string      expTag[$];
  logic [5:0] lastVec = '0;
  logic [5:0] vec;
  assign vec = {oscEn, oscFast, vccEn, ioEn, clkEn, cardRst};

  task automatic push(logic [5:0] v, int c, string t);
    expVec.push_back(v);
    expCyc.push_back(c);
    expTag.push_back(t);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic waitTo(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // full power-down from the fully active state, first edge at d
  task automatic expectDown(int d, int g, bit rstOn, string t);
    if (rstOn) push(6'b111110, d, t);
    push(6'b111100, d + g,     t);
    push(6'b111000, d + 2 * g, t);
    push(6'b110000, d + 3 * g, t);
    push(6'b000000, d + 4 * g, t);
  endtask

  task automatic activate(int g, string t);
    int n;
    n = cyc;
    actCmdN = 1'b0;
    push(6'b100000, n + 1,         t);
    push(6'b110000, n + 1 + g,     t);
    push(6'b111000, n + 1 + 2 * g, t);
    push(6'b111100, n + 1 + 3 * g, t);
    push(6'b111110, n + 1 + 4 * g, t);
    waitTo(n + 1 + 5 * g + 2);
  endtask

  // scoreboard monitor: every output change must match the next expected item
  always @(negedge clk) begin : monitor
    logic [5:0] v;
    int         c;
    string      t;
    if (rstN && !done && vec != lastVec) begin
      checks++;
      if (expVec.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected output change actual %b expected %b at cycle %0d",
                 vec, lastVec, cyc);
      end else begin
        v = expVec.pop_front();
        c = expCyc.pop_front();
        t = expTag.pop_front();
        if (v != vec || c != cyc) begin
          errors++;
          $display("FAIL %s actual %b@%0d expected %b@%0d", t, vec, cyc, v, c);
        end
      end
      lastVec = vec;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin : driver
    int n, m, d, r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 outputs", int'(vec), 0);
    chk("R1 alertN", int'(alertN), 0);

    // R7/R4: command and host reset with card absent have no effect
    n = cyc;
    actCmdN = 1'b0;
    hostRst = 1'b1;
    waitTo(n + 10);
    chk("R7 absent oscEn", int'(oscEn), 0);
    chk("R4 cardRst gated", int'(cardRst), 0);
    actCmdN = 1'b1;
    hostRst = 1'b0;
    waitTo(n + 12);

    // R8: bounce restarts the stability count
    n = cyc;
    presRawN = 1'b0;
    waitTo(n + 20);
    presRawN = 1'b1;
    waitTo(n + 22);
    presRawN = 1'b0;
    m = cyc;
    waitTo(m + 20);
    chk("R8 bounce not accepted", int'(alertN), 0);
    waitTo(m + DEB + 1);
    chk("R8 one cycle early", int'(alertN), 0);
    waitTo(m + DEB + 2);
    chk("R8 accepted", int'(alertN), 1);

    // R2/R3: activation, gap 5
    waitTo(cyc + 2);
    activate(5, "R3 gap5");
    chk("R9 status after activation", int'(alertN), 1);

    // R4: reset follows host
    m = cyc;
    hostRst = 1'b1;
    push(6'b111111, m + 1, "R4 rise");
    waitTo(m + 4);
    hostRst = 1'b0;
    push(6'b111110, m + 5, "R4 fall");
    waitTo(m + 7);
    hostRst = 1'b1;
    push(6'b111111, cyc + 1, "R4 rise2");
    waitTo(cyc + 3);

    // R5/R6: requested power-down; R7: new fall during power-down ignored
    d = cyc;
    actCmdN = 1'b1;
    expectDown(d + 1, 5, 1'b1, "R6 cmd down");
    waitTo(d + 3);
    actCmdN = 1'b0;
    waitTo(d + 1 + 20 + 3);
    chk("R7 ignored during down", int'(oscEn), 0);
    chk("R9 requested down keeps status", int'(alertN), 1);
    hostRst = 1'b0;
    actCmdN = 1'b1;
    waitTo(cyc + 2);

    // R10: overtemperature part-way through power-up, gap 3
    stepGap = 8'd3;
    n = cyc;
    actCmdN = 1'b0;
    push(6'b100000, n + 1, "R3 gap3");
    push(6'b110000, n + 4, "R3 gap3");
    push(6'b111000, n + 7, "R3 gap3");
    waitTo(n + 8);
    faultOvertemp = 1'b1;
    d = n + 9;
    push(6'b110000, d + 9,  "R10 vcc off");
    push(6'b000000, d + 12, "R10 osc off");
    waitTo(d);
    chk("R9 forced down status", int'(alertN), 0);
    waitTo(d + 14);
    chk("R10 io never on", int'(ioEn), 0);

    // R7: fresh command while fault held
    actCmdN = 1'b1;
    waitTo(cyc + 2);
    actCmdN = 1'b0;
    waitTo(cyc + 6);
    chk("R7 fault blocks start", int'(oscEn), 0);
    faultOvertemp = 1'b0;
    actCmdN = 1'b1;
    waitTo(cyc + 2);
    activate(3, "R3 regain");
    chk("R9 status cleared by activation", int'(alertN), 1);

    // R5: card removal after debounce
    r = cyc;
    presRawN = 1'b1;
    d = r + DEB + 3;
    expectDown(d, 3, 1'b0, "R5 removal");
    waitTo(r + DEB + 1);
    chk("R8 removal not yet", int'(alertN), 1);
    waitTo(r + DEB + 2);
    chk("R9 removal status", int'(alertN), 0);
    waitTo(d + 14);

    // R2: card returns with command already low: no start
    stepGap = 8'd0;
    presRawN = 1'b0;
    waitTo(cyc + DEB + 4);
    chk("R2 level does not start", int'(oscEn), 0);
    chk("R9 latched after removal", int'(alertN), 0);

    // R3: gap of zero acts as one
    actCmdN = 1'b1;
    waitTo(cyc + 2);
    activate(1, "R3 gap0");
    chk("R9 status gap0", int'(alertN), 1);

    // R5: supply alarm trigger
    m = cyc;
    supplyAlarm = 1'b1;
    expectDown(m + 1, 1, 1'b0, "R5 alarm");
    waitTo(m + 8);
    supplyAlarm = 1'b0;
    chk("R9 alarm status", int'(alertN), 0);

    waitTo(cyc + 5);
    chk("R6 pending expectations", expVec.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule